// File: doc/BRIEF.md
# Four-Word Burst DDR SRAM Controller

This block is a synchronous bus master for a double-data-rate SRAM whose every access is a fixed burst of four words spread over two clock periods. A user presents one request per handshake: a direction, a word address, and for writes four data words with per-byte enables. The controller turns that request into a single load cycle on the memory bus, sends or collects the four words over two cycles, and for reads hands back all four words together with a one-cycle valid pulse.

The two lowest address bits choose the word the burst starts on; the memory walks the remaining words modulo four. On the user side, word slot `i` always belongs to the address whose low bits equal `i`, so the controller rotates write words into burst order and rotates read words back. Each clock cycle carries two words, modelled as a rising-edge lane and a falling-edge lane, each with its own active-low byte-write mask.

Top module: `ddrb_ctrl`

## Requirements
- R1: During and right after reset, `mem_ld_no` is 1, `req_ready_o` is 1, `rsp_valid_o` is 0 and both byte-mask lanes are all ones.
- R2: A request accepted at a clock edge (`req_valid_i` and `req_ready_o` both high) drives `mem_ld_no` low for exactly the following cycle, with `mem_addr_o` equal to the request address and `mem_rw_o` 1 for a read or 0 for a write.
- R3: `req_ready_o` is low in each load cycle, so two load cycles are always at least two cycles apart; back-to-back requests reach one burst every two cycles.
- R4: For a write with start offset `s` (address bits [1:0]), the load cycle carries user word `s` on the rising lane and word `(s+1) mod 4` on the falling lane; the next cycle carries words `(s+2) mod 4` and `(s+3) mod 4`.
- R5: The byte-mask lane that travels with write word `j` equals the bitwise inverse of that word's user byte enables (mask bit 0 = write the byte); in every slot that is not write data, both mask lanes are all ones and the data lanes are zero.
- R6: For a read loaded in cycle `t`, the memory returns burst words 0 and 1 (rising, falling) in cycle `t+RD_LAT` and words 2 and 3 in cycle `t+RD_LAT+1`; `rsp_valid_o` is high for exactly cycle `t+RD_LAT+2`, with user slot `i` of `rsp_rdata_o` (bits `i*DW` upward) holding the word for address low bits `i`.
- R7: Every start offset 0 to 3 is handled, for both reads and writes, with the rotation wrapping modulo four.
- R8: A request offered while `req_ready_o` is low is ignored: it produces no load cycle.
- R9: Reads issued back to back return their responses in issue order, one per two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address; bits [1:0] give the burst start |
| req_wdata_i | input | 4*DW | Write words, slot i for address low bits i |
| req_wbe_i | input | 4*BW | Byte enables, active high, slot i for word i |
| rsp_valid_o | output | 1 | One-cycle pulse, read data valid |
| rsp_rdata_o | output | 4*DW | Read words, slot i for address low bits i |
| mem_ld_no | output | 1 | Load strobe, active low |
| mem_rw_o | output | 1 | 1 = read, 0 = write, meaningful in load cycle |
| mem_addr_o | output | AW | Burst address |
| mem_wd_rise_o | output | DW | Write data, rising-edge lane |
| mem_wd_fall_o | output | DW | Write data, falling-edge lane |
| mem_bw_rise_no | output | BW | Byte-write mask, rising lane, active low |
| mem_bw_fall_no | output | BW | Byte-write mask, falling lane, active low |
| mem_rd_rise_i | input | DW | Read data, rising-edge lane |
| mem_rd_fall_i | input | DW | Read data, falling-edge lane |

## Verification
On every cycle the assertions hold the load strobe to single-cycle pulses spaced by at least one idle cycle, tie each load to the address and direction of the handshake that caused it, forbid a load after a cycle with ready low, keep the masks all ones outside write data, and keep the response a single-cycle pulse. Only the scenarios show the word rotation for each start offset, the per-edge mask pairing, the read latency counted from the load, and in-order return of back-to-back reads; they are compared against a memory model and queues built from the requirements.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  localparam int unsigned BURST_LEN = 4;
  typedef logic [1:0] slot_t;

  // burst position k of a burst starting at off, wrapped mod 4
  function automatic slot_t slot_at(slot_t off, slot_t k);
    slot_t r;
    r = off + k;
    return r;
  endfunction
endpackage

// File: rtl/ddrb_issue.sv
module ddrb_issue #(
  parameter int unsigned AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          fire_o,
  output logic          ld_no,
  output logic          rw_o,
  output logic [AW-1:0] addr_o
);
  logic          busy_q;
  logic          ld_n_q, rw_q;
  logic [AW-1:0] addr_q;

  assign req_ready_o = ~busy_q;
  assign fire_o      = req_valid_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ld_n_q <= 1'b1;
      rw_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      busy_q <= fire_o;
      if (fire_o) begin
        ld_n_q <= 1'b0;
        rw_q   <= ~req_write_i;
        addr_q <= req_addr_i;
      end else begin
        ld_n_q <= 1'b1;
        rw_q   <= 1'b1;
      end
    end
  end

  assign ld_no  = ld_n_q;
  assign rw_o   = rw_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/ddrb_wlane.sv
module ddrb_wlane
  import ddrb_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fire_i,
  input  logic                    write_i,
  input  slot_t                   off_i,
  input  logic [BURST_LEN*DW-1:0] wdata_i,
  input  logic [BURST_LEN*BW-1:0] wbe_i,
  output logic [DW-1:0]           rise_o,
  output logic [DW-1:0]           fall_o,
  output logic [BW-1:0]           bwr_no,
  output logic [BW-1:0]           bwf_no
);
  logic [DW-1:0] word [BURST_LEN];
  logic [BW-1:0] msk  [BURST_LEN];

  for (genvar i = 0; i < BURST_LEN; i++) begin : g_split
    assign word[i] = wdata_i[i*DW +: DW];
    assign msk[i]  = ~wbe_i[i*BW +: BW];
  end

  slot_t s0, s1, s2, s3;
  assign s0 = slot_at(off_i, 2'd0);
  assign s1 = slot_at(off_i, 2'd1);
  assign s2 = slot_at(off_i, 2'd2);
  assign s3 = slot_at(off_i, 2'd3);

  logic          pend_q;
  logic [DW-1:0] hr_q, hf_q;
  logic [BW-1:0] hmr_q, hmf_q;
  logic [DW-1:0] rise_q, fall_q;
  logic [BW-1:0] bwr_q, bwf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hr_q   <= '0;
      hf_q   <= '0;
      hmr_q  <= '1;
      hmf_q  <= '1;
      rise_q <= '0;
      fall_q <= '0;
      bwr_q  <= '1;
      bwf_q  <= '1;
    end else if (fire_i && write_i) begin
      rise_q <= word[s0];
      fall_q <= word[s1];
      bwr_q  <= msk[s0];
      bwf_q  <= msk[s1];
      hr_q   <= word[s2];
      hf_q   <= word[s3];
      hmr_q  <= msk[s2];
      hmf_q  <= msk[s3];
      pend_q <= 1'b1;
    end else if (pend_q) begin
      rise_q <= hr_q;
      fall_q <= hf_q;
      bwr_q  <= hmr_q;
      bwf_q  <= hmf_q;
      pend_q <= 1'b0;
    end else begin
      rise_q <= '0;
      fall_q <= '0;
      bwr_q  <= '1;
      bwf_q  <= '1;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign bwr_no = bwr_q;
  assign bwf_no = bwf_q;
endmodule

// File: rtl/ddrb_rcap.sv
module ddrb_rcap
  import ddrb_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned RD_LAT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_rd_i,
  input  slot_t                   off_i,
  input  logic [DW-1:0]           rd_rise_i,
  input  logic [DW-1:0]           rd_fall_i,
  output logic                    rsp_valid_o,
  output logic [BURST_LEN*DW-1:0] rsp_rdata_o
);
  // stage k holds the load seen k+1 cycles ago
  logic [RD_LAT:0]       pv_q;
  logic [RD_LAT:0][1:0]  po_q;
  logic [DW-1:0]         f0_q, f1_q;
  logic                  vld_q;
  logic [BURST_LEN*DW-1:0] data_q;

  logic [DW-1:0] burst [BURST_LEN];
  logic [BURST_LEN*DW-1:0] asm_d;
  slot_t off_last;

  assign burst[0] = f0_q;
  assign burst[1] = f1_q;
  assign burst[2] = rd_rise_i;
  assign burst[3] = rd_fall_i;
  assign off_last = po_q[RD_LAT];

  for (genvar i = 0; i < BURST_LEN; i++) begin : g_unrot
    slot_t pos;
    assign pos = slot_t'(i) - off_last;
    assign asm_d[i*DW +: DW] = burst[pos];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q   <= '0;
      po_q   <= '0;
      f0_q   <= '0;
      f1_q   <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      pv_q <= {pv_q[RD_LAT-1:0], ld_rd_i};
      po_q <= {po_q[RD_LAT-1:0], off_i};
      if (pv_q[RD_LAT-1]) begin
        f0_q <= rd_rise_i;
        f1_q <= rd_fall_i;
      end
      vld_q <= pv_q[RD_LAT];
      if (pv_q[RD_LAT]) data_q <= asm_d;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_rdata_o = data_q;
endmodule

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl
  import ddrb_pkg::*;
#(
  parameter int unsigned AW     = 20,
  parameter int unsigned DW     = 32,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned BW    = DW / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [AW-1:0]           req_addr_i,
  input  logic [BURST_LEN*DW-1:0] req_wdata_i,
  input  logic [BURST_LEN*BW-1:0] req_wbe_i,
  output logic                    rsp_valid_o,
  output logic [BURST_LEN*DW-1:0] rsp_rdata_o,
  output logic                    mem_ld_no,
  output logic                    mem_rw_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [DW-1:0]           mem_wd_rise_o,
  output logic [DW-1:0]           mem_wd_fall_o,
  output logic [BW-1:0]           mem_bw_rise_no,
  output logic [BW-1:0]           mem_bw_fall_no,
  input  logic [DW-1:0]           mem_rd_rise_i,
  input  logic [DW-1:0]           mem_rd_fall_i
);
  logic fire;

  ddrb_issue #(.AW(AW)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_ready_o (req_ready_o),
    .fire_o      (fire),
    .ld_no       (mem_ld_no),
    .rw_o        (mem_rw_o),
    .addr_o      (mem_addr_o)
  );

  ddrb_wlane #(.DW(DW)) u_wlane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .write_i (req_write_i),
    .off_i   (req_addr_i[1:0]),
    .wdata_i (req_wdata_i),
    .wbe_i   (req_wbe_i),
    .rise_o  (mem_wd_rise_o),
    .fall_o  (mem_wd_fall_o),
    .bwr_no  (mem_bw_rise_no),
    .bwf_no  (mem_bw_fall_no)
  );

  ddrb_rcap #(.DW(DW), .RD_LAT(RD_LAT)) u_rcap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_rd_i     (~mem_ld_no & mem_rw_o),
    .off_i       (mem_addr_o[1:0]),
    .rd_rise_i   (mem_rd_rise_i),
    .rd_fall_i   (mem_rd_fall_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/ddrb_ctrl_chk.sv
module ddrb_ctrl_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic          rsp_valid_o,
  input logic          mem_ld_no,
  input logic          mem_rw_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [BW-1:0] mem_bw_rise_no,
  input logic [BW-1:0] mem_bw_fall_no
);
  assert_load_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (!mem_ld_no && mem_addr_o == $past(req_addr_i) && mem_rw_o == !$past(req_write_i)));

  assert_load_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ld_no |=> mem_ld_no);

  assert_no_load_unready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> mem_ld_no);

  assert_read_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ld_no && mem_rw_o) |=> ((&mem_bw_rise_no) && (&mem_bw_fall_no)));

  assert_idle_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ld_no && $past(mem_ld_no)) |-> ((&mem_bw_rise_no) && (&mem_bw_fall_no)));

  assert_rsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind ddrb_ctrl ddrb_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_write_i    (req_write_i),
  .req_addr_i     (req_addr_i),
  .rsp_valid_o    (rsp_valid_o),
  .mem_ld_no      (mem_ld_no),
  .mem_rw_o       (mem_rw_o),
  .mem_addr_o     (mem_addr_o),
  .mem_bw_rise_no (mem_bw_rise_no),
  .mem_bw_fall_no (mem_bw_fall_no)
);

// File: tb/ddrb_ctrl_test.sv
`timescale 1ns/1ps
module ddrb_ctrl_test;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid, req_ready, req_write;
  logic [AW-1:0]     req_addr;
  logic [4*DW-1:0]   req_wdata;
  logic [4*BW-1:0]   req_wbe;
  logic              rsp_valid;
  logic [4*DW-1:0]   rsp_rdata;
  logic              ld_n, rw;
  logic [AW-1:0]     maddr;
  logic [DW-1:0]     wd_r, wd_f, rd_r, rd_f;
  logic [BW-1:0]     bw_r, bw_f;

  ddrb_ctrl #(.AW(AW), .DW(DW), .RD_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_wbe_i(req_wbe),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_ld_no(ld_n), .mem_rw_o(rw), .mem_addr_o(maddr),
    .mem_wd_rise_o(wd_r), .mem_wd_fall_o(wd_f),
    .mem_bw_rise_no(bw_r), .mem_bw_fall_no(bw_f),
    .mem_rd_rise_i(rd_r), .mem_rd_fall_i(rd_f)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [4*DW-1:0] act, logic [4*DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return DW'(a) * 32'h9E37_79B1 + 32'h5A5A_0F0F;
  endfunction

  // scoreboard queues
  logic [AW:0]        cmd_q[$];   // {rw, addr}
  logic [4*DW-1:0]    wexp_q[$];  // burst order words
  logic [4*BW-1:0]    wmsk_q[$];  // burst order masks, active low
  logic [4*DW-1:0]    rexp_q[$];  // user order words
  int                 due_q[$];
  int accepted = 0, loads = 0;

  // driver
  task automatic do_req(bit wr, logic [AW-1:0] a, logic [4*DW-1:0] wd, logic [4*BW-1:0] be);
    logic [1:0] off;
    logic [4*DW-1:0] bo, ue;
    logic [4*BW-1:0] bm;
    while (!req_ready) @(negedge clk);
    off = a[1:0];
    for (int k = 0; k < 4; k++) begin
      logic [1:0] s;
      s = off + 2'(k);
      bo[k*DW +: DW] = wd[s*DW +: DW];
      bm[k*BW +: BW] = ~be[s*BW +: BW];
      ue[k*DW +: DW] = mem_word({a[AW-1:2], 2'(k)});
    end
    cmd_q.push_back({~wr, a});
    if (wr) begin
      wexp_q.push_back(bo);
      wmsk_q.push_back(bm);
    end else rexp_q.push_back(ue);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_wbe = be;
    accepted++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model and monitor
  int cyc = 0;
  int last_ld = -10;
  logic [DW-1:0] sr [8];
  logic [DW-1:0] sf [8];
  bit wpend = 0;
  logic [2*DW-1:0] wp_d;
  logic [2*BW-1:0] wp_m;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!ld_n) begin
        logic [AW:0] c;
        loads++;
        chk(cyc - last_ld >= 2, "R3 load spacing", 128'(cyc - last_ld), 128'd2);
        last_ld = cyc;
        if (cmd_q.size() == 0) chk(0, "R8 unexpected load", 128'({rw, maddr}), 0);
        else begin
          c = cmd_q.pop_front();
          chk({rw, maddr} == c, "R2 load command", 128'({rw, maddr}), 128'(c));
        end
        if (rw) begin
          logic [AW-1:0] b;
          b = {maddr[AW-1:2], 2'b00};
          sr[(cyc+LAT)%8]   = mem_word(b | AW'(maddr[1:0]));
          sf[(cyc+LAT)%8]   = mem_word(b | AW'(2'(maddr[1:0] + 2'd1)));
          sr[(cyc+LAT+1)%8] = mem_word(b | AW'(2'(maddr[1:0] + 2'd2)));
          sf[(cyc+LAT+1)%8] = mem_word(b | AW'(2'(maddr[1:0] + 2'd3)));
          due_q.push_back(cyc + LAT + 2);
          chk((&bw_r) && (&bw_f), "R5 read masks", 128'({bw_r, bw_f}), '1);
        end else if (wexp_q.size() > 0) begin
          logic [4*DW-1:0] e;
          logic [4*BW-1:0] m;
          e = wexp_q.pop_front();
          m = wmsk_q.pop_front();
          chk({wd_f, wd_r} == e[2*DW-1:0], "R4 write first pair", 128'({wd_f, wd_r}), 128'(e[2*DW-1:0]));
          chk({bw_f, bw_r} == m[2*BW-1:0], "R5 write first masks", 128'({bw_f, bw_r}), 128'(m[2*BW-1:0]));
          wp_d = e[4*DW-1:2*DW];
          wp_m = m[4*BW-1:2*BW];
          wpend = 1;
        end
      end else if (wpend) begin
        chk({wd_f, wd_r} == wp_d, "R4 write second pair", 128'({wd_f, wd_r}), 128'(wp_d));
        chk({bw_f, bw_r} == wp_m, "R5 write second masks", 128'({bw_f, bw_r}), 128'(wp_m));
        wpend = 0;
      end else begin
        chk((&bw_r) && (&bw_f) && wd_r == 0 && wd_f == 0, "R5 idle lanes",
            128'({bw_r, bw_f, wd_r}), 128'({{2*BW{1'b1}}, {DW{1'b0}}}));
      end
      if (rsp_valid) begin
        if (rexp_q.size() == 0) chk(0, "R6 unexpected response", rsp_rdata, 0);
        else begin
          logic [4*DW-1:0] e;
          int d;
          e = rexp_q.pop_front();
          d = due_q.pop_front();
          chk(cyc == d, "R6 read latency", 128'(cyc), 128'(d));
          chk(rsp_rdata == e, "R6 R7 R9 read data", rsp_rdata, e);
        end
      end
    end
    rd_r = sr[cyc%8];
    rd_f = sf[cyc%8];
    sr[cyc%8] = '0;
    sf[cyc%8] = '0;
    if (cyc > 20000 && !done) begin
      done = 1;
      chk(0, "watchdog", 128'(cyc), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [4*DW-1:0] pat(int seed);
    logic [4*DW-1:0] r;
    for (int i = 0; i < 4; i++) r[i*DW +: DW] = 32'hC0DE_0000 + 32'(seed * 16 + i);
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin sr[i] = '0; sf[i] = '0; end
    rd_r = '0; rd_f = '0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_wbe = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ld_n == 1'b1, "R1 ld_n", 128'(ld_n), 1);
    chk(req_ready == 1'b1, "R1 ready", 128'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 128'(rsp_valid), 0);
    chk((&bw_r) && (&bw_f), "R1 masks", 128'({bw_r, bw_f}), '1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_n == 1'b1 && req_ready == 1'b1, "R1 after reset", 128'({ld_n, req_ready}), 128'(2'b11));

    // R4 R5 R7 writes at every offset, varied masks
    for (int o = 0; o < 4; o++)
      do_req(1, AW'(32'h100 + o), pat(o), 16'hFFFF ^ (16'h1 << (o * 5)));
    repeat (3) @(negedge clk);
    do_req(1, AW'(32'h2F2), pat(9), 16'h0F3C);
    repeat (2) @(negedge clk);

    // R6 R7 reads at every offset, spaced
    for (int o = 0; o < 4; o++) begin
      do_req(0, AW'(32'h340 + o * 5), '0, '0);
      repeat (6) @(negedge clk);
    end

    // R3 R9 back-to-back reads and mixed traffic
    for (int i = 0; i < 6; i++) do_req(0, AW'(32'h8000 + i * 3), '0, '0);
    for (int i = 0; i < 4; i++) do_req(i[0], AW'(32'h1234 + i), pat(20 + i), 16'hA5C3);
    repeat (8) @(negedge clk);

    // R8 request while not ready is ignored
    do_req(1, AW'(32'h77), pat(40), 16'hFFFF);
    // ready is low in this cycle (load cycle)
    chk(req_ready == 1'b0, "R3 ready low in load cycle", 128'(req_ready), 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(32'h55);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(loads == accepted, "R8 load count", 128'(loads), 128'(accepted));
    chk(cmd_q.size() == 0 && rexp_q.size() == 0 && wexp_q.size() == 0,
        "R9 queues drained", 128'(cmd_q.size() + rexp_q.size()), 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule